// File: doc/BRIEF.md
# Two-Thread Congestion Throttle and Decode Slot Sharer

This block sits beside the decode stage of a core that runs two hardware threads at once. For each thread it watches three numbers: outstanding second-level cache load misses, outstanding translation misses, and the reorder-buffer entries the thread currently holds. When a thread's combined miss count or its reorder-buffer share climbs past a programmable high mark, the thread is marked congested. It stays congested until every watched quantity has fallen to or below a lower release mark.

While a thread stays congested, the block tightens its response in steps. First the thread's decode priority is halved. Next its decode is blocked outright. Finally a one-cycle flush request is issued for its instructions waiting for dispatch, and decode stays blocked. Each step lasts a programmable number of cycles. When the congestion clears, the thread returns to full priority at once.

Decode cycles are handed out in repeating frames. Each thread's number of slots in a frame equals its effective priority. The block drives control signals only. The reorder buffer, the caches and the flush datapath lie outside it.

Top module: `smt_throttle`

## Requirements
- R1: After reset, both throttle levels are 0, and no decode block and no flush request is asserted.
- R2: A thread becomes congested when the sum of its cache-miss count and its translation-miss count, taken as an unsigned (CNT_W+1)-bit sum, is at least `miss_hi_i`. Its level then reads 1 two rising edges after the inputs change.
- R3: A thread also becomes congested when its reorder-buffer count is at least `rob_hi_i`, with the same two-edge latency.
- R4: A congested thread stays congested while its miss sum exceeds `miss_lo_i` or its reorder-buffer count exceeds `rob_lo_i`, even if both are below their high marks.
- R5: While congested, the level goes from 1 to 2 and from 2 to 3 after `step_i` cycles at each level (a `step_i` of 0 counts as 1). Level 3 is then held. Levels are encoded 0 = none, 1 = lowered priority, 2 = decode blocked, 3 = flushed; each thread's level is a 2-bit field of `level_o`, with thread 0 in bits 1:0.
- R6: On the first edge at which a thread is found clear, its congested flag drops. Its level reads 0, and its decode block is removed, one edge later.
- R7: The effective priority is the programmed priority at level 0 and the priority shifted right by one at level 1. At level 2 or 3 it is 0 and the thread's `dec_block_o` bit is high.
- R8: `flush_o` for a thread is high for exactly the one cycle in which its level first reads 3, and it stays low while level 3 is held.
- R9: Decode slots repeat in frames of eff0+eff1 cycles. Thread 0 takes its eff0 slots first and thread 1 then takes eff1. Over any window of whole frames, each thread's grant count is proportional to its effective priority.
- R10: A blocked thread receives no grant, and the other thread then receives every cycle as long as its effective priority is nonzero.
- R11: When both effective priorities are 0, no grant is issued.
- R12: At most one bit of `grant_o` is high in any cycle (bit 0 is thread 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| l2_miss_i | input | 2*CNT_W | Outstanding cache load misses per thread, thread 0 low |
| tlb_miss_i | input | 2*CNT_W | Outstanding translation misses per thread |
| rob_used_i | input | 2*ROB_W | Reorder-buffer entries held per thread |
| prio_i | input | 2*PRIO_W | Programmed decode priority per thread |
| miss_hi_i | input | CNT_W+1 | Miss-sum level that starts congestion |
| miss_lo_i | input | CNT_W+1 | Miss-sum level at or below which congestion may clear |
| rob_hi_i | input | ROB_W | Reorder-buffer level that starts congestion |
| rob_lo_i | input | ROB_W | Reorder-buffer level at or below which congestion may clear |
| step_i | input | STEP_W | Cycles spent at each level before escalating |
| level_o | output | 4 | Throttle level per thread, 2 bits each |
| eff_prio_o | output | 2*PRIO_W | Effective priority per thread |
| dec_block_o | output | 2 | Decode blocked per thread |
| flush_o | output | 2 | One-cycle flush request per thread |
| grant_o | output | 2 | Decode slot owner this cycle |

## Verification
The bench sets a thread's miss sum exactly equal to the high mark. A design that used a strict compare would never throttle that thread. It then lowers the sum into the band between the two marks and checks that the level holds. A design without hysteresis would release the thread there. It drops the sum exactly to the low mark and checks that release takes one step with no walk back through the levels. It times each escalation to the cycle and checks that the flush request stays a single pulse, so a design that held the request at level 3 would fail. Grant counts are taken over whole frames, with both a block on one thread and both priorities at zero, to catch a slot sharer that leaks grants to a blocked thread or issues two grants at once.

// File: rtl/smt_throttle_pkg.sv
package smt_throttle_pkg;
  localparam int unsigned N_THR = 2;

  typedef enum logic [1:0] {
    THR_NONE   = 2'd0,
    THR_LOWPRI = 2'd1,
    THR_BLOCK  = 2'd2,
    THR_FLUSH  = 2'd3
  } thr_lvl_e;
endpackage

// File: rtl/thr_detect.sv
module thr_detect #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned ROB_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] l2_miss_i,
  input  logic [CNT_W-1:0] tlb_miss_i,
  input  logic [ROB_W-1:0] rob_used_i,
  input  logic [CNT_W:0]   miss_hi_i,
  input  logic [CNT_W:0]   miss_lo_i,
  input  logic [ROB_W-1:0] rob_hi_i,
  input  logic [ROB_W-1:0] rob_lo_i,
  output logic             cong_o
);
  localparam int unsigned SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] miss_sum;
  logic             over_hi, at_or_below_lo, cong_d, cong_q;

  assign miss_sum       = {1'b0, l2_miss_i} + {1'b0, tlb_miss_i};
  assign over_hi        = (miss_sum >= miss_hi_i) || (rob_used_i >= rob_hi_i);
  assign at_or_below_lo = (miss_sum <= miss_lo_i) && (rob_used_i <= rob_lo_i);

  // hysteresis: set on high mark, clear only when all quantities at/below low mark
  always_comb begin
    if (cong_q) cong_d = !at_or_below_lo;
    else        cong_d = over_hi;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cong_q <= 1'b0;
    else         cong_q <= cong_d;
  end

  assign cong_o = cong_q;

  AST_SET_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cong_q) |-> $past(over_hi)) else $error("congestion set without high mark"); // R2
endmodule

// File: rtl/thr_fsm.sv
module thr_fsm
  import smt_throttle_pkg::*;
#(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned STEP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cong_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic [1:0]        level_o,
  output logic [PRIO_W-1:0] eff_o,
  output logic              block_o,
  output logic              flush_o
);
  thr_lvl_e          lvl_q, lvl_d;
  logic [STEP_W-1:0] tmr_q, tmr_d;
  logic              flush_q, step_done;

  assign step_done = ({1'b0, tmr_q} + (STEP_W+1)'(1)) >= {1'b0, step_i};

  always_comb begin
    lvl_d = lvl_q;
    tmr_d = tmr_q;
    if (!cong_i) begin
      lvl_d = THR_NONE;
      tmr_d = '0;
    end else begin
      unique case (lvl_q)
        THR_NONE: begin
          lvl_d = THR_LOWPRI;
          tmr_d = '0;
        end
        THR_LOWPRI, THR_BLOCK: begin
          if (step_done) begin
            lvl_d = (lvl_q == THR_LOWPRI) ? THR_BLOCK : THR_FLUSH;
            tmr_d = '0;
          end else begin
            tmr_d = tmr_q + STEP_W'(1);
          end
        end
        default: tmr_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= THR_NONE;
      tmr_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      tmr_q   <= tmr_d;
      flush_q <= (lvl_d == THR_FLUSH) && (lvl_q != THR_FLUSH);
    end
  end

  always_comb begin
    unique case (lvl_q)
      THR_NONE:   eff_o = prio_i;
      THR_LOWPRI: eff_o = prio_i >> 1;
      default:    eff_o = '0;
    endcase
  end

  assign level_o = lvl_q;
  assign block_o = (lvl_q == THR_BLOCK) || (lvl_q == THR_FLUSH);
  assign flush_o = flush_q;

  AST_FLUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |=> !flush_q) else $error("flush held"); // R8
  AST_FLUSH_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |-> (lvl_q == THR_FLUSH)) else $error("flush outside top level"); // R8
  AST_ESC_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != THR_FLUSH) |=> ({1'b0, lvl_q} <= ({1'b0, $past(lvl_q)} + 3'd1)))
    else $error("level skipped"); // R5
endmodule

// File: rtl/thr_share.sv
module thr_share #(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned N_T    = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_T*PRIO_W-1:0] eff_i,
  output logic [N_T-1:0]        grant_o
);
  logic [N_T-1:0][PRIO_W-1:0] cred_q, cred_d, clamp, avail;
  logic                       frame_end, found;

  always_comb begin
    frame_end = 1'b1;
    for (int i = 0; i < N_T; i++) begin
      // credits never exceed the current priority, so a demoted thread loses slots at once
      clamp[i] = (cred_q[i] < eff_i[i*PRIO_W +: PRIO_W]) ? cred_q[i] : eff_i[i*PRIO_W +: PRIO_W];
      if (clamp[i] != '0) frame_end = 1'b0;
    end
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N_T; i++) begin
      avail[i] = frame_end ? eff_i[i*PRIO_W +: PRIO_W] : clamp[i];
      if (!found && (avail[i] != '0)) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
      cred_d[i] = avail[i] - PRIO_W'(grant_o[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cred_q <= '0;
    else         cred_q <= cred_d;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)) else $error("two grants"); // R12
endmodule

// File: rtl/smt_throttle.sv
module smt_throttle
  import smt_throttle_pkg::*;
#(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned ROB_W  = 7,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned STEP_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2*CNT_W-1:0]      l2_miss_i,
  input  logic [2*CNT_W-1:0]      tlb_miss_i,
  input  logic [2*ROB_W-1:0]      rob_used_i,
  input  logic [2*PRIO_W-1:0]     prio_i,
  input  logic [CNT_W:0]          miss_hi_i,
  input  logic [CNT_W:0]          miss_lo_i,
  input  logic [ROB_W-1:0]        rob_hi_i,
  input  logic [ROB_W-1:0]        rob_lo_i,
  input  logic [STEP_W-1:0]       step_i,
  output logic [3:0]              level_o,
  output logic [2*PRIO_W-1:0]     eff_prio_o,
  output logic [1:0]              dec_block_o,
  output logic [1:0]              flush_o,
  output logic [1:0]              grant_o
);
  logic [N_THR-1:0] cong;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    thr_detect #(.CNT_W(CNT_W), .ROB_W(ROB_W)) i_detect (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .l2_miss_i  (l2_miss_i[t*CNT_W +: CNT_W]),
      .tlb_miss_i (tlb_miss_i[t*CNT_W +: CNT_W]),
      .rob_used_i (rob_used_i[t*ROB_W +: ROB_W]),
      .miss_hi_i  (miss_hi_i),
      .miss_lo_i  (miss_lo_i),
      .rob_hi_i   (rob_hi_i),
      .rob_lo_i   (rob_lo_i),
      .cong_o     (cong[t])
    );

    thr_fsm #(.PRIO_W(PRIO_W), .STEP_W(STEP_W)) i_fsm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cong_i  (cong[t]),
      .step_i  (step_i),
      .prio_i  (prio_i[t*PRIO_W +: PRIO_W]),
      .level_o (level_o[t*2 +: 2]),
      .eff_o   (eff_prio_o[t*PRIO_W +: PRIO_W]),
      .block_o (dec_block_o[t]),
      .flush_o (flush_o[t])
    );
  end

  thr_share #(.PRIO_W(PRIO_W), .N_T(N_THR)) i_share (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .eff_i   (eff_prio_o),
    .grant_o (grant_o)
  );

  AST_BLOCK_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_block_o & grant_o) == 2'b00) else $error("grant to blocked thread"); // R10
  AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_prio_o == '0) |-> (grant_o == 2'b00)) else $error("grant with zero priorities"); // R11
endmodule

// File: tb/test_smt_throttle.sv
module test_smt_throttle;
  localparam int CNT_W = 5, ROB_W = 7, PRIO_W = 3, STEP_W = 8;
  localparam int STEP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2*CNT_W-1:0]  l2_miss = '0, tlb_miss = '0;
  logic [2*ROB_W-1:0]  rob_used = '0;
  logic [2*PRIO_W-1:0] prio = '0;
  logic [3:0]          level;
  logic [2*PRIO_W-1:0] eff_prio;
  logic [1:0]          dec_block, flush, grant;

  smt_throttle #(.CNT_W(CNT_W), .ROB_W(ROB_W), .PRIO_W(PRIO_W), .STEP_W(STEP_W)) i_smt_throttle (
    .clk_i(clk), .rst_ni(rst_n), .l2_miss_i(l2_miss), .tlb_miss_i(tlb_miss),
    .rob_used_i(rob_used), .prio_i(prio), .miss_hi_i(6'd8), .miss_lo_i(6'd3),
    .rob_hi_i(7'd40), .rob_lo_i(7'd20), .step_i(8'(STEP)),
    .level_o(level), .eff_prio_o(eff_prio), .dec_block_o(dec_block),
    .flush_o(flush), .grant_o(grant)
  );

  // sel: 0 lvl t0, 1 lvl t1, 2 block, 3 flush, 4 grant, 5 eff t0, 6 eff t1, -1 precomputed act
  typedef struct { int due; int sel; int exp; int act; string req; } item_t;
  item_t sb[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  function automatic int observe(int sel);
    case (sel)
      0: return int'(level[1:0]);
      1: return int'(level[3:2]);
      2: return int'(dec_block);
      3: return int'(flush);
      4: return int'(grant);
      5: return int'(eff_prio[2:0]);
      default: return int'(eff_prio[5:3]);
    endcase
  endfunction

  task automatic expect_at(int off, int sel, int exp, string req);
    item_t it;
    it.due = cyc + off; it.sel = sel; it.exp = exp; it.act = 0; it.req = req;
    sb.push_back(it);
  endtask

  task automatic expect_val(int act, int exp, string req);
    item_t it;
    it.due = cyc + 1; it.sel = -1; it.exp = exp; it.act = act; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: pops due items and compares at the falling edge
  always @(negedge clk) begin
    item_t it;
    int a;
    if (rst_n) begin
      cyc++;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        it = sb.pop_front();
        a = (it.sel < 0) ? it.act : observe(it.sel);
        n_chk++;
        if (a != it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d cyc=%0d", it.req, it.sel, a, it.exp, cyc);
        end
      end
    end
  end

  task automatic drive_slot();
    @(posedge clk); #1;
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    drive_slot();
  endtask

  task automatic count_win(int n, int e0, int e1, string req);
    int c0 = 0, c1 = 0, both = 0;
    repeat (n) begin
      @(negedge clk); #0.1;
      if (grant[0]) c0++;
      if (grant[1]) c1++;
      if (grant == 2'b11) both++;
    end
    #0.5;
    expect_val(c0, e0, {req, " t0 slots"});
    expect_val(c1, e1, {req, " t1 slots"});
    expect_val(both, 0, "R12 double grant");
  endtask

  initial begin
    prio = {3'd2, 3'd6};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    drive_slot();
    expect_at(1, 0, 0, "R1 lvl t0");
    expect_at(1, 1, 0, "R1 lvl t1");
    expect_at(1, 2, 0, "R1 block");
    expect_at(1, 3, 0, "R1 flush");
    drain();

    count_win(8, 6, 2, "R9 prio 6:2");
    drain();

    // thread 0 miss sum exactly at high mark
    l2_miss[4:0] = 5'd5; tlb_miss[4:0] = 5'd3;
    expect_at(3, 0, 1, "R2 lvl t0 -> 1");
    expect_at(3, 5, 3, "R7 halved eff t0");
    expect_at(5, 0, 1, "R5 lvl 1 held");
    expect_at(6, 0, 2, "R5 lvl t0 -> 2");
    expect_at(6, 2, 1, "R7 block t0");
    expect_at(6, 5, 0, "R7 eff t0 zero");
    expect_at(8, 3, 0, "R8 no early flush");
    expect_at(9, 0, 3, "R5 lvl t0 -> 3");
    expect_at(9, 3, 1, "R8 flush pulse");
    expect_at(10, 3, 0, "R8 flush single");
    expect_at(12, 0, 3, "R5 lvl 3 held");
    expect_at(12, 4, 2, "R10 other thread granted");
    expect_at(14, 3, 0, "R8 no repeat flush");
    drain();

    // sum 4: between marks, stays congested
    tlb_miss[4:0] = 5'd1; l2_miss[4:0] = 5'd3;
    expect_at(5, 0, 3, "R4 hysteresis hold");
    drain();

    // sum 3: exactly at low mark, releases
    tlb_miss[4:0] = 5'd0;
    expect_at(2, 0, 3, "R6 before release");
    expect_at(3, 0, 0, "R6 lvl t0 -> 0");
    expect_at(3, 2, 0, "R6 block cleared");
    expect_at(3, 5, 6, "R7 full eff restored");
    drain();

    // thread 1 reorder-buffer occupancy at high mark
    rob_used[13:7] = 7'd40;
    expect_at(3, 1, 1, "R3 lvl t1 -> 1");
    expect_at(3, 6, 1, "R7 halved eff t1");
    drain();
    rob_used[13:7] = 7'd10;
    expect_at(3, 1, 0, "R6 lvl t1 -> 0");
    drain();

    prio = '0;
    expect_at(1, 4, 0, "R11 no grant");
    expect_at(3, 4, 0, "R11 no grant later");
    drain();

    prio = {3'd3, 3'd1};
    repeat (4) drive_slot();
    count_win(8, 2, 6, "R9 prio 1:3");
    drain();

    repeat (3) drive_slot();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule